// File: doc/BRIEF.md
# Serial FPGA Configuration Sequencer

This block loads a configuration bitstream into a downstream FPGA through a three-wire serial path: an active-low program strobe, a configuration clock and a data line. A pulse on the start input makes the sequencer put the target into reset and then release it. It waits for the target's init line to answer each step. It then takes bytes from a ready/valid stream and clocks them out one bit at a time, and finally waits for the target's done line. Each wait has its own time limit, and each limit has its own error code.

When the load succeeds, the sequencer resets the freshly configured logic. It keeps program and the configuration clock high and drives the data line low for a set time, then high for the same time. The busy flag covers the whole run. The success flag and the error code describe the last run and hold until the next start. All time limits and the clock divider are parameters counted in system-clock cycles.

Top module: `fpga_cfg_seq`

## Requirements
- R1: Out of reset, tgt_prog_n_o=1, tgt_cclk_o=0, tgt_din_o=1, busy_o=0, byte_ready_o=0, cfg_ok_o=0 and err_o=0.
- R2: A start pulse seen while idle raises busy_o on the next cycle and clears cfg_ok_o and err_o. tgt_prog_n_o stays high for that one cycle and goes low on the cycle after. busy_o then stays high until the run ends with success or an error.
- R3: tgt_prog_n_o stays low until tgt_init_i is seen low, for at most INIT_LOW_TO sampled cycles. If tgt_init_i is still high after that, the run ends with err_o=1 and tgt_prog_n_o high.
- R4: Once init is seen low, tgt_prog_n_o is released. tgt_init_i must then be seen high within INIT_HIGH_TO cycles, otherwise the run ends with err_o=2.
- R5: byte_ready_o is high only while the sequencer waits for the next byte. A byte is accepted only on a cycle where byte_ready_o and byte_valid_i are both high. While byte_valid_i is low, the outputs do not move.
- R6: Each byte is sent most significant bit first. For each bit, tgt_din_o is set while tgt_cclk_o is low for CLK_HALF cycles, then tgt_cclk_o is high for CLK_HALF cycles, and tgt_din_o does not change across the rising edge.
- R7: A byte accepted with byte_last_i=1 ends the stream. After its last bit, tgt_cclk_o stays low and tgt_done_i must be seen high within DONE_TO cycles, otherwise the run ends with err_o=3.
- R8: After done is seen, tgt_prog_n_o and tgt_cclk_o are held high while tgt_din_o is low for RST_CYCLES cycles and then high for RST_CYCLES cycles. The run then ends with cfg_ok_o=1, err_o=0 (success) and busy_o=0.
- R9: start_i is ignored while busy_o is high. Such a pulse does not pulse the program strobe again and does not alter the run.
- R10: While idle, cfg_ok_o and err_o keep the result of the last run until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a configuration run |
| byte_i | input | DW | Bitstream byte |
| byte_valid_i | input | 1 | byte_i holds a byte |
| byte_last_i | input | 1 | byte_i is the final byte of the stream |
| byte_ready_o | output | 1 | Sequencer accepts a byte this cycle |
| tgt_init_i | input | 1 | Target init status line |
| tgt_done_i | input | 1 | Target done status line |
| tgt_prog_n_o | output | 1 | Target program strobe, active low |
| tgt_cclk_o | output | 1 | Configuration clock |
| tgt_din_o | output | 1 | Configuration data |
| busy_o | output | 1 | Run in progress |
| cfg_ok_o | output | 1 | Last run completed successfully |
| err_o | output | 2 | Last run result: 0 success, 1 init-low, 2 init-high, 3 done timeout |

## Verification
A wrong state in this block shows at the pins within one cycle. The program strobe, the configuration clock, the data line and the ready flag are all decoded straight from the state and the shift register. So a skipped or repeated state, an off-by-one timer or a wrong bit order makes the model and the pins disagree in the first cycle after the mistake. A wrong timeout count shows as the strobe released, or the error code posted, one cycle early or late. The bench checks this at both sides of each limit. A mis-ordered bit shows as a wrong data level, either at the next comparison or in the bits the target model latches on rising clock edges.

// File: rtl/fpga_cfg_pkg.sv
package fpga_cfg_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PROG_HI,
    ST_PROG_LO,
    ST_INIT_WAIT,
    ST_LOAD,
    ST_BIT_LO,
    ST_BIT_HI,
    ST_DONE_WAIT,
    ST_RST_LO,
    ST_RST_HI
  } cfg_state_e;

  typedef enum logic [1:0] {
    ERR_NONE      = 2'd0,
    ERR_INIT_LOW  = 2'd1,
    ERR_INIT_HIGH = 2'd2,
    ERR_DONE      = 2'd3
  } cfg_err_e;

endpackage

// File: rtl/fpga_cfg_timer.sv
module fpga_cfg_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [CW-1:0] limit_i,
  output logic          hit_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = (cnt_q == limit_i);

endmodule

// File: rtl/fpga_cfg_shifter.sv
module fpga_cfg_shifter #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic          last_i,
  input  logic          shift_i,
  input  logic          force_i,
  input  logic          force_val_i,
  output logic          din_o,
  output logic          bit_last_o,
  output logic          byte_last_o
);

  localparam int BW = (DW > 1) ? $clog2(DW) : 1;

  logic [DW-1:0] sr_q;
  logic [BW-1:0] bidx_q;
  logic          last_q;
  logic          din_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      bidx_q <= '0;
      last_q <= 1'b0;
      din_q  <= 1'b1;
    end else if (load_i) begin
      sr_q   <= data_i;
      bidx_q <= BW'(DW - 1);
      last_q <= last_i;
      din_q  <= data_i[DW-1];
    end else if (shift_i) begin
      sr_q   <= {sr_q[DW-2:0], 1'b0};
      bidx_q <= bidx_q - 1'b1;
      din_q  <= sr_q[DW-2];
    end else if (force_i) begin
      din_q  <= force_val_i;
    end
  end

  assign din_o       = din_q;
  assign bit_last_o  = (bidx_q == '0);
  assign byte_last_o = last_q;

endmodule

// File: rtl/fpga_cfg_seq.sv
module fpga_cfg_seq
  import fpga_cfg_pkg::*;
#(
  parameter int DW           = 8,
  parameter int CLK_HALF     = 2,
  parameter int INIT_LOW_TO  = 1000,
  parameter int INIT_HIGH_TO = 1000,
  parameter int DONE_TO      = 100000,
  parameter int RST_CYCLES   = 100000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] byte_i,
  input  logic          byte_valid_i,
  input  logic          byte_last_i,
  output logic          byte_ready_o,
  input  logic          tgt_init_i,
  input  logic          tgt_done_i,
  output logic          tgt_prog_n_o,
  output logic          tgt_cclk_o,
  output logic          tgt_din_o,
  output logic          busy_o,
  output logic          cfg_ok_o,
  output logic [1:0]    err_o
);

  localparam int M_INIT = (INIT_LOW_TO > INIT_HIGH_TO) ? INIT_LOW_TO : INIT_HIGH_TO;
  localparam int M_TAIL = (DONE_TO > RST_CYCLES) ? DONE_TO : RST_CYCLES;
  localparam int M_WAIT = (M_INIT > M_TAIL) ? M_INIT : M_TAIL;
  localparam int M_ALL  = (M_WAIT > CLK_HALF) ? M_WAIT : CLK_HALF;
  localparam int CW     = $clog2(M_ALL + 1);

  localparam logic [CW-1:0] LIM_ILO  = CW'(INIT_LOW_TO - 1);
  localparam logic [CW-1:0] LIM_IHI  = CW'(INIT_HIGH_TO - 1);
  localparam logic [CW-1:0] LIM_HALF = CW'(CLK_HALF - 1);
  localparam logic [CW-1:0] LIM_DONE = CW'(DONE_TO - 1);
  localparam logic [CW-1:0] LIM_RST  = CW'(RST_CYCLES - 1);

  cfg_state_e    st_q, st_d;
  logic [CW-1:0] limit;
  logic          hit;
  logic          load, shift, force_din, force_val;
  logic          bit_last, byte_last;
  logic          res_clear, ok_set, err_set;
  cfg_err_e      err_code;
  logic          ok_q;
  logic [1:0]    err_q;

  always_comb begin
    unique case (st_q)
      ST_PROG_LO:            limit = LIM_ILO;
      ST_INIT_WAIT:          limit = LIM_IHI;
      ST_BIT_LO, ST_BIT_HI:  limit = LIM_HALF;
      ST_DONE_WAIT:          limit = LIM_DONE;
      ST_RST_LO, ST_RST_HI:  limit = LIM_RST;
      default:               limit = '0;
    endcase
  end

  fpga_cfg_timer #(.CW(CW)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (st_d != st_q),
    .limit_i (limit),
    .hit_o   (hit)
  );

  fpga_cfg_shifter #(.DW(DW)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .data_i      (byte_i),
    .last_i      (byte_last_i),
    .shift_i     (shift),
    .force_i     (force_din),
    .force_val_i (force_val),
    .din_o       (tgt_din_o),
    .bit_last_o  (bit_last),
    .byte_last_o (byte_last)
  );

  always_comb begin
    st_d      = st_q;
    load      = 1'b0;
    shift     = 1'b0;
    force_din = 1'b0;
    force_val = 1'b0;
    res_clear = 1'b0;
    ok_set    = 1'b0;
    err_set   = 1'b0;
    err_code  = ERR_NONE;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        st_d      = ST_PROG_HI;
        res_clear = 1'b1;
        force_din = 1'b1;
        force_val = 1'b1;
      end
      ST_PROG_HI: st_d = ST_PROG_LO;
      ST_PROG_LO: begin
        if (!tgt_init_i) st_d = ST_INIT_WAIT;
        else if (hit) begin
          st_d     = ST_IDLE;
          err_set  = 1'b1;
          err_code = ERR_INIT_LOW;
        end
      end
      ST_INIT_WAIT: begin
        if (tgt_init_i) st_d = ST_LOAD;
        else if (hit) begin
          st_d     = ST_IDLE;
          err_set  = 1'b1;
          err_code = ERR_INIT_HIGH;
        end
      end
      ST_LOAD: if (byte_valid_i) begin
        load = 1'b1;
        st_d = ST_BIT_LO;
      end
      ST_BIT_LO: if (hit) st_d = ST_BIT_HI;
      ST_BIT_HI: if (hit) begin
        if (!bit_last) begin
          shift = 1'b1;
          st_d  = ST_BIT_LO;
        end else begin
          st_d = byte_last ? ST_DONE_WAIT : ST_LOAD;
        end
      end
      ST_DONE_WAIT: begin
        if (tgt_done_i) begin
          st_d      = ST_RST_LO;
          force_din = 1'b1;
          force_val = 1'b0;
        end else if (hit) begin
          st_d     = ST_IDLE;
          err_set  = 1'b1;
          err_code = ERR_DONE;
        end
      end
      ST_RST_LO: if (hit) begin
        st_d      = ST_RST_HI;
        force_din = 1'b1;
        force_val = 1'b1;
      end
      ST_RST_HI: if (hit) begin
        st_d   = ST_IDLE;
        ok_set = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      ok_q  <= 1'b0;
      err_q <= 2'd0;
    end else begin
      st_q <= st_d;
      if (res_clear) begin
        ok_q  <= 1'b0;
        err_q <= 2'd0;
      end else if (ok_set) begin
        ok_q  <= 1'b1;
      end else if (err_set) begin
        err_q <= err_code;
      end
    end
  end

  assign tgt_prog_n_o = (st_q != ST_PROG_LO);
  assign tgt_cclk_o   = (st_q == ST_BIT_HI) || (st_q == ST_RST_LO) || (st_q == ST_RST_HI);
  assign byte_ready_o = (st_q == ST_LOAD);
  assign busy_o       = (st_q != ST_IDLE);
  assign cfg_ok_o     = ok_q;
  assign err_o        = err_q;

endmodule

// File: rtl/fpga_cfg_seq_chk.sv
module fpga_cfg_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       byte_ready_o,
  input logic       tgt_done_i,
  input logic       tgt_prog_n_o,
  input logic       tgt_cclk_o,
  input logic       tgt_din_o,
  input logic       busy_o,
  input logic       cfg_ok_o,
  input logic [1:0] err_o
);

  AST_READY_IN_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_ready_o |-> busy_o && tgt_prog_n_o && !tgt_cclk_o); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> tgt_prog_n_o && !tgt_cclk_o && !byte_ready_o); // R2

  AST_PROG_AFTER_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tgt_prog_n_o) |-> $past(busy_o)); // R2

  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(start_i && !busy_o) |-> busy_o && !cfg_ok_o && err_o == 2'd0); // R2

  AST_DIN_STABLE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(tgt_cclk_o) && !$past(tgt_done_i)) |-> $stable(tgt_din_o)); // R6

  AST_OK_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_ok_o |-> err_o == 2'd0); // R8

  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && $past(!busy_o && !start_i)) |-> $stable(err_o) && $stable(cfg_ok_o)); // R10

endmodule

bind fpga_cfg_seq fpga_cfg_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .byte_ready_o (byte_ready_o),
  .tgt_done_i   (tgt_done_i),
  .tgt_prog_n_o (tgt_prog_n_o),
  .tgt_cclk_o   (tgt_cclk_o),
  .tgt_din_o    (tgt_din_o),
  .busy_o       (busy_o),
  .cfg_ok_o     (cfg_ok_o),
  .err_o        (err_o)
);

// File: tb/sim_fpga_cfg_seq.sv
module sim_fpga_cfg_seq;

  localparam int CLK_PERIOD = 10;
  localparam int T_HALF = 2;
  localparam int T_ILO  = 6;
  localparam int T_IHI  = 8;
  localparam int T_DONE = 10;
  localparam int T_RST  = 4;
  localparam int NEVER  = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i;
  logic [7:0] byte_i;
  logic       byte_valid_i;
  logic       byte_last_i;
  logic       byte_ready_o;
  logic       tgt_init_i;
  logic       tgt_done_i;
  logic       tgt_prog_n_o;
  logic       tgt_cclk_o;
  logic       tgt_din_o;
  logic       busy_o;
  logic       cfg_ok_o;
  logic [1:0] err_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpga_cfg_seq #(
    .DW(8), .CLK_HALF(T_HALF), .INIT_LOW_TO(T_ILO), .INIT_HIGH_TO(T_IHI),
    .DONE_TO(T_DONE), .RST_CYCLES(T_RST)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i),
    .byte_i(byte_i), .byte_valid_i(byte_valid_i), .byte_last_i(byte_last_i),
    .byte_ready_o(byte_ready_o), .tgt_init_i(tgt_init_i), .tgt_done_i(tgt_done_i),
    .tgt_prog_n_o(tgt_prog_n_o), .tgt_cclk_o(tgt_cclk_o), .tgt_din_o(tgt_din_o),
    .busy_o(busy_o), .cfg_ok_o(cfg_ok_o), .err_o(err_o)
  );

  // scenario configuration (written only by the main process)
  int         sid = 0;
  logic [7:0] bq[$];
  int         a_dly, b_dly, d_dly;
  bit         gaps;

  // ---------------- reference model ----------------
  logic e_prog, e_cclk, e_din, e_busy, e_ready, e_ok;
  logic [1:0] e_err;

  task automatic set_exp(logic p, logic c, logic d, logic b, logic r);
    e_prog = p; e_cclk = c; e_din = d; e_busy = b; e_ready = r;
  endtask

  task automatic fail_exp(logic [1:0] c);
    set_exp(1'b1, 1'b0, e_din, 1'b0, 1'b0);
    e_err = c;
  endtask

  task automatic model_seq();
    int n;
    logic [7:0] byt;
    logic lst;
    e_ok = 1'b0; e_err = 2'd0;
    set_exp(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    @(posedge clk);
    set_exp(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    n = 0;
    forever begin
      @(posedge clk);
      if (!tgt_init_i) break;
      if (n == T_ILO - 1) begin fail_exp(2'd1); return; end
      n++;
    end
    set_exp(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    n = 0;
    forever begin
      @(posedge clk);
      if (tgt_init_i) break;
      if (n == T_IHI - 1) begin fail_exp(2'd2); return; end
      n++;
    end
    lst = 1'b0;
    while (!lst) begin
      set_exp(1'b1, 1'b0, e_din, 1'b1, 1'b1);
      forever begin
        @(posedge clk);
        if (byte_valid_i) break;
      end
      byt = byte_i;
      lst = byte_last_i;
      for (int b = 7; b >= 0; b--) begin
        set_exp(1'b1, 1'b0, byt[b], 1'b1, 1'b0);
        repeat (T_HALF) @(posedge clk);
        set_exp(1'b1, 1'b1, byt[b], 1'b1, 1'b0);
        repeat (T_HALF) @(posedge clk);
      end
    end
    set_exp(1'b1, 1'b0, e_din, 1'b1, 1'b0);
    n = 0;
    forever begin
      @(posedge clk);
      if (tgt_done_i) break;
      if (n == T_DONE - 1) begin fail_exp(2'd3); return; end
      n++;
    end
    set_exp(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    repeat (T_RST) @(posedge clk);
    set_exp(1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    repeat (T_RST) @(posedge clk);
    set_exp(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    e_ok = 1'b1;
  endtask

  initial begin
    set_exp(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    e_ok = 1'b0; e_err = 2'd0;
    forever begin
      @(posedge clk);
      if (rst_n && start_i) model_seq();
    end
  end

  // ---------------- per-cycle comparison ----------------
  task automatic cmp(string tag, string name, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, name, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      cmp("R2", "prog_n", tgt_prog_n_o, e_prog);
      cmp("R6", "cclk",   tgt_cclk_o,   e_cclk);
      cmp("R6", "din",    tgt_din_o,    e_din);
      cmp("R2", "busy",   busy_o,       e_busy);
      cmp("R5", "ready",  byte_ready_o, e_ready);
      cmp("R8", "ok",     cfg_ok_o,     e_ok);
      cmp("R10", "err",   err_o,        e_err);
    end
  end

  // ---------------- target model ----------------
  int   emu_sid = -1;
  int   lo_cnt, hi_cnt, bitcnt, dcnt, nfall;
  logic prev_prog, prev_cclk;
  logic cap [0:63];

  always @(negedge clk) begin
    if (!rst_n || sid != emu_sid) begin
      emu_sid = sid;
      tgt_init_i = 1'b1; tgt_done_i = 1'b0;
      lo_cnt = 0; hi_cnt = 0; bitcnt = 0; dcnt = 0; nfall = 0;
    end else begin
      if (prev_prog && !tgt_prog_n_o) nfall++;
      if (!tgt_prog_n_o) begin
        lo_cnt++; hi_cnt = 0; bitcnt = 0; dcnt = 0; tgt_done_i = 1'b0;
        if (lo_cnt >= a_dly) tgt_init_i = 1'b0;
      end else begin
        lo_cnt = 0;
        if (!tgt_init_i) begin
          hi_cnt++;
          if (hi_cnt >= b_dly) tgt_init_i = 1'b1;
        end
        if (tgt_cclk_o && !prev_cclk && bitcnt < 8 * bq.size()) begin
          cap[bitcnt] = tgt_din_o;
          bitcnt++;
        end else if (bq.size() > 0 && bitcnt == 8 * bq.size()) begin
          dcnt++;
          if (dcnt >= d_dly) tgt_done_i = 1'b1;
        end
      end
    end
    prev_prog = tgt_prog_n_o;
    prev_cclk = tgt_cclk_o;
  end

  // ---------------- byte source ----------------
  int src_sid = -1;
  int ptr, vcnt;
  bit pending;

  always @(negedge clk) begin
    if (!rst_n || sid != src_sid) begin
      src_sid = sid; ptr = 0; vcnt = 0; pending = 0;
    end else if (pending) begin
      ptr++;
    end
    vcnt++;
    byte_valid_i = gaps ? (vcnt % 3 != 0) : 1'b1;
    byte_i       = (ptr < bq.size()) ? bq[ptr] : 8'h00;
    byte_last_i  = (ptr == bq.size() - 1);
    pending      = byte_ready_o && byte_valid_i;
  end

  // ---------------- scenarios ----------------
  task automatic run(string name, int a, int b, int d, bit g, bit extra,
                     logic [1:0] exp_err, string tag);
    int k;
    @(negedge clk);
    sid++; a_dly = a; b_dly = b; d_dly = d; gaps = g;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    k = 0;
    while (busy_o && k < 5000) begin
      @(negedge clk);
      k++;
      start_i = (extra && k == 5);
    end
    start_i = 1'b0;
    cmp(tag, {name, " err code"}, err_o, exp_err);
    cmp(tag, {name, " ok flag"}, cfg_ok_o, exp_err == 2'd0);
    cmp("R9", {name, " program pulses"}, nfall, 1);
    if (exp_err == 2'd0) begin
      for (int i = 0; i < 8 * bq.size(); i++)
        cmp("R6", {name, " bit order"}, cap[i], bq[i/8][7 - (i % 8)]);
    end
  endtask

  initial begin
    start_i = 1'b0;
    gaps = 0; a_dly = 1; b_dly = 1; d_dly = 1;
    repeat (3) @(negedge clk);
    cmp("R1", "reset prog_n", tgt_prog_n_o, 1);
    cmp("R1", "reset cclk",   tgt_cclk_o,   0);
    cmp("R1", "reset din",    tgt_din_o,    1);
    cmp("R1", "reset busy",   busy_o,       0);
    cmp("R1", "reset ready",  byte_ready_o, 0);
    cmp("R1", "reset ok",     cfg_ok_o,     0);
    cmp("R1", "reset err",    err_o,        0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    bq = '{8'hA5, 8'h3C};
    run("basic", 2, 3, 2, 0, 0, 2'd0, "R8");
    bq = '{8'h81, 8'h7E, 8'hC3};
    run("edge-limits gaps restart", T_ILO, T_IHI, 5, 1, 1, 2'd0, "R5");
    bq = '{8'h11};
    run("init-low timeout", T_ILO + 1, 1, 1, 0, 0, 2'd1, "R3");
    repeat (6) @(negedge clk);
    cmp("R10", "held err", err_o, 2'd1);
    run("init-high timeout", 1, T_IHI + 1, 1, 0, 0, 2'd2, "R4");
    bq = '{8'h5A};
    run("done timeout", 1, 1, NEVER, 0, 0, 2'd3, "R7");
    repeat (4) @(negedge clk);
    cmp("R10", "held err after done timeout", err_o, 2'd3);
    bq = '{8'hFF, 8'h00};
    run("recover", 1, 1, 1, 1, 0, 2'd0, "R2");
    repeat (4) @(negedge clk);
    cmp("R10", "held ok", cfg_ok_o, 1);

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule